// File: doc/BRIEF.md
# Write-Only Register Readback Sequencer

This block keeps a shadow copy of setup registers that cannot be read in the usual way. It covers two cascaded legacy interrupt controllers and the upper four-channel DMA controller. It snoops every I/O write on a simple bus and decodes the interrupt-controller initialization and operation command words. It also decodes the DMA command, request and per-channel mode writes, and stores each value in its own shadow register.

When the alternate access input is high, software can read the shadows back. Successive reads of the master interrupt command port return the twelve interrupt-controller words in a fixed order. Successive reads of the DMA command port return the six DMA words in a fixed order. Bits that the controllers treat as reserved are not stored faithfully on readback. They come back as fixed values, or as a copy of a neighbouring bit, so software never sees the values it wrote into them.

Top module: `wo_shadow_readback`

## Requirements
- R1: A write to a controller's command port (20h master, A0h slave) with bit 4 set is ICW1. It starts an initialization sequence: the following writes to that controller's data port (21h or A1h) are stored as ICW2, then ICW3, then ICW4.
- R2: Within that sequence, ICW3 is skipped when ICW1 bit 1 is set (single mode). ICW4 is skipped when ICW1 bit 0 is clear. The data-port write after the sequence ends is stored as OCW1.
- R3: Outside an initialization sequence, a data-port write is stored as OCW1. A command-port write with bit 4 clear is stored as OCW2 when bit 3 is 0, and as OCW3 when bit 3 is 1.
- R4: A write to D0h stores the DMA command, a write to D2h stores the DMA request, and a write to D6h stores a mode value for the channel that its bits 1:0 select (00 is channel 4, 11 is channel 7).
- R5: While alternate mode is on, successive reads at 20h return, in order: master ICW2, ICW3, ICW4, OCW1, OCW2, OCW3, then the same six words for the slave.
- R6: While alternate mode is on, successive reads at D0h return, in order: the command, the request, then the modes of channels 4, 5, 6 and 7. Bits 1:0 of each mode word read as the channel code 00, 01, 10, 11.
- R7: On readback, ICW2 bits 2:0 read 000. ICW4 bits 7:5, 3:2 and 0 read 0, so only ICW4 bits 4 and 1 come from the stored value. This applies to both controllers.
- R8: On readback, OCW2 bits 4:3 read 00. For OCW3, bit 7 reads 0, bits 4:3 read 01 and bit 5 reads the stored bit 6. This applies to both controllers.
- R9: On readback, DMA command bits 5, 3, 1 and 0 read 0.
- R10: Each port has its own read index. The index is zero while alternate mode is off. It advances by one on each read of its own port only, and wraps to zero after the last entry.
- R11: The read data is 0 when alternate mode is off, or when the read is not at 20h or D0h. Reads under those conditions move no index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_mode_en | input | 1 | Alternate access mode enable |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one write per cycle it is high |
| io_rd | input | 1 | Read strobe, one read per cycle it is high |
| io_rdata | output | 8 | Read data, combinational from the address and the read index |

## Verification
The bench runs full and shortened initialization sequences. A design that ignored the single-mode or ICW4 flags would either overwrite ICW3 or ICW4 with a later word, or store that word in the wrong place. The bench also reads one port a thirteenth time and interleaves reads of the two ports. A design sharing one index between the ports, or failing to wrap, would return a word out of order or garbage. It reads back values whose reserved bits were written the opposite way, including an OCW3 whose bit 6 differs from its stored bit 5. A design that passed reserved bits through would return the raw write. Finally it leaves and re-enters alternate mode partway through a list, which a design that kept the old index would reveal.

// File: rtl/wo_rb_pkg.sv
// Package: shared types, widths and readback views for the shadow readback block.
// Assumes an 8-bit I/O data path.
package wo_rb_pkg;

    localparam int DATA_W = 8;

    // Initialization sequence state of one interrupt controller
    typedef enum logic [1:0] {
        INIT_IDLE = 2'd0,
        INIT_W2   = 2'd1,
        INIT_W3   = 2'd2,
        INIT_W4   = 2'd3
    } init_st_e;

    // Shadow copy of one interrupt controller's write-only words
    typedef struct packed {
        logic [DATA_W-1:0] icw2;
        logic [DATA_W-1:0] icw3;
        logic [DATA_W-1:0] icw4;
        logic [DATA_W-1:0] ocw1;
        logic [DATA_W-1:0] ocw2;
        logic [DATA_W-1:0] ocw3;
    } pic_shadow_t;

    localparam int PIC_WORDS = 6;

    // Readback value of ICW2: vector base only, low three bits forced low
    function automatic logic [DATA_W-1:0] view_icw2(input logic [DATA_W-1:0] v);
        return v & 8'hF8;
    endfunction

    // Readback value of ICW4: keep bits 4 and 1 only
    function automatic logic [DATA_W-1:0] view_icw4(input logic [DATA_W-1:0] v);
        return v & 8'h12;
    endfunction

    // Readback value of OCW2: bits 4:3 forced low
    function automatic logic [DATA_W-1:0] view_ocw2(input logic [DATA_W-1:0] v);
        return v & 8'hE7;
    endfunction

    // Readback value of OCW3: bit 7 low, bit 5 mirrors bit 6, bits 4:3 = 01
    function automatic logic [DATA_W-1:0] view_ocw3(input logic [DATA_W-1:0] v);
        return {1'b0, v[6], v[6], 2'b01, v[2:0]};
    endfunction

    // Readback value of DMA command: bits 5, 3, 1 and 0 forced low
    function automatic logic [DATA_W-1:0] view_dcmd(input logic [DATA_W-1:0] v);
        return v & 8'hD4;
    endfunction

endpackage

// File: rtl/pic_shadow.sv
// Module: pic_shadow
// Snoops writes to one interrupt controller's command port (CMD_ADDR) and data
// port (CMD_ADDR+1), tracks its initialization sequence and stores every
// write-only word as written. Assumes one write per cycle that io_wr is high.
module pic_shadow
    import wo_rb_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output pic_shadow_t       regs
);

    localparam logic [ADDR_W-1:0] DATA_ADDR = CMD_ADDR + ADDR_W'(1);

    init_st_e state;
    logic     single_q;
    logic     need4_q;

    logic cmd_wr;
    logic data_wr;
    logic is_icw1;

    // Decode the port a write targets
    always_comb begin
        cmd_wr  = io_wr && (io_addr == CMD_ADDR);
        data_wr = io_wr && (io_addr == DATA_ADDR);
        is_icw1 = cmd_wr && io_wdata[4];
    end

    // Initialization sequence tracker and ICW1 flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= INIT_IDLE;
            single_q <= 1'b0;
            need4_q  <= 1'b0;
        end else if (is_icw1) begin
            state    <= INIT_W2;
            single_q <= io_wdata[1];
            need4_q  <= io_wdata[0];
        end else if (data_wr) begin
            unique case (state)
                INIT_W2: state <= !single_q ? INIT_W3 : (need4_q ? INIT_W4 : INIT_IDLE);
                INIT_W3: state <= need4_q ? INIT_W4 : INIT_IDLE;
                INIT_W4: state <= INIT_IDLE;
                default: state <= INIT_IDLE;
            endcase
        end
    end

    // Store each decoded word into its shadow register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (data_wr && !is_icw1) begin
            unique case (state)
                INIT_W2: regs.icw2 <= io_wdata;
                INIT_W3: regs.icw3 <= io_wdata;
                INIT_W4: regs.icw4 <= io_wdata;
                default: regs.ocw1 <= io_wdata;
            endcase
        end else if (cmd_wr && !io_wdata[4]) begin
            if (io_wdata[3]) regs.ocw3 <= io_wdata;
            else             regs.ocw2 <= io_wdata;
        end
    end

    // R1: a data write during ICW2 wait always leaves that state
    p_init_leaves_w2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == INIT_W2 && data_wr) |=> (state != INIT_W2));

    // R2: single mode never passes through the ICW3 wait
    p_single_skips_w3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == INIT_W2 && data_wr && single_q) |=> (state != INIT_W3));

    // R3: data writes during initialization leave OCW1 untouched
    p_ocw1_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state != INIT_IDLE) |=> $stable(regs.ocw1));

endmodule

// File: rtl/dma_shadow.sv
// Module: dma_shadow
// Snoops writes to the upper DMA controller's command, request and mode ports
// and stores them. A mode write is routed by its low channel-code bits. Only
// the upper bits of a mode value are kept; the code is rebuilt on readback.
module dma_shadow
    import wo_rb_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                N_CH      = 4,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 16'h00D0,
    parameter logic [ADDR_W-1:0] REQ_ADDR  = 16'h00D2,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 16'h00D6,
    localparam int               CH_W      = $clog2(N_CH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr,
    input  logic [ADDR_W-1:0]      io_addr,
    input  logic [DATA_W-1:0]      io_wdata,
    output logic [DATA_W-1:0]      cmd_q,
    output logic [DATA_W-1:0]      req_q,
    output logic [DATA_W-CH_W-1:0] mode_hi_q [N_CH]
);

    logic mode_wr;

    // Decode a mode-port write
    always_comb mode_wr = io_wr && (io_addr == MODE_ADDR);

    // Command and request shadows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            req_q <= '0;
        end else if (io_wr) begin
            if (io_addr == CMD_ADDR) cmd_q <= io_wdata;
            if (io_addr == REQ_ADDR) req_q <= io_wdata;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic sel;

        // Channel select from the mode word's code bits
        always_comb sel = mode_wr && (io_wdata[CH_W-1:0] == CH_W'(c));

        // Per-channel mode shadow
        always_ff @(posedge clk) begin
            if (!rst_n)   mode_hi_q[c] <= '0;
            else if (sel) mode_hi_q[c] <= io_wdata[DATA_W-1:CH_W];
        end

        // R4: a mode write with another channel code leaves this channel alone
        p_mode_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_wr && io_wdata[CH_W-1:0] != CH_W'(c)) |=> $stable(mode_hi_q[c]));
    end

endmodule

// File: rtl/seq_index.sv
// Module: seq_index
// Read pointer for one readback port: zero while the mode is off, advances on
// each read step and wraps after DEPTH entries. Assumes DEPTH >= 2.
module seq_index #(
    parameter int  DEPTH = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // Pointer update: clear when disabled, wrap at the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  idx <= '0;
        else if (step)      idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
    end

    // R10: pointer never leaves the list
    p_idx_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);

    // R10: pointer is zero in the cycle after the mode was off
    p_idx_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> idx == '0);

    // R10: pointer holds when there is no read of its port
    p_idx_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(idx));

endmodule

// File: rtl/wo_shadow_readback.sv
// Module: wo_shadow_readback (top)
// Shadows the write-only words of a master/slave interrupt controller pair and
// the upper DMA controller. While alt_mode_en is high, it plays them back in a
// fixed order on reads of the master command port and the DMA command port,
// with reserved bits replaced. io_rdata is combinational; a read is counted on
// each clock edge where io_rd is high.
module wo_shadow_readback
    import wo_rb_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PIC_M_ADDR = 16'h0020,
    parameter logic [ADDR_W-1:0] PIC_S_ADDR = 16'h00A0,
    parameter logic [ADDR_W-1:0] DMA_CMD    = 16'h00D0,
    parameter logic [ADDR_W-1:0] DMA_REQ    = 16'h00D2,
    parameter logic [ADDR_W-1:0] DMA_MODE   = 16'h00D6,
    parameter int                N_DMA_CH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_mode_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [7:0]        io_rdata
);

    localparam int N_PIC   = 2;
    localparam int PIC_LEN = N_PIC * PIC_WORDS;
    localparam int DMA_LEN = 2 + N_DMA_CH;
    localparam int CH_W    = $clog2(N_DMA_CH);
    localparam int PIDX_W  = $clog2(PIC_LEN);
    localparam int DIDX_W  = $clog2(DMA_LEN);

    pic_shadow_t              pic_regs  [N_PIC];
    logic [DATA_W-1:0]        dma_cmd_q;
    logic [DATA_W-1:0]        dma_req_q;
    logic [DATA_W-CH_W-1:0]   dma_mode_q [N_DMA_CH];
    logic [DATA_W-1:0]        pic_view  [PIC_LEN];
    logic [DATA_W-1:0]        dma_view  [DMA_LEN];
    logic [PIDX_W-1:0]        pic_idx;
    logic [DIDX_W-1:0]        dma_idx;
    logic                     rd_pic;
    logic                     rd_dma;

    // One shadow per interrupt controller, master first
    for (genvar g = 0; g < N_PIC; g++) begin : g_pic
        pic_shadow #(
            .ADDR_W   (ADDR_W),
            .CMD_ADDR ((g == 0) ? PIC_M_ADDR : PIC_S_ADDR)
        ) i_pic_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .io_wr    (io_wr),
            .io_addr  (io_addr),
            .io_wdata (io_wdata),
            .regs     (pic_regs[g])
        );
    end

    dma_shadow #(
        .ADDR_W    (ADDR_W),
        .N_CH      (N_DMA_CH),
        .CMD_ADDR  (DMA_CMD),
        .REQ_ADDR  (DMA_REQ),
        .MODE_ADDR (DMA_MODE)
    ) i_dma_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_wdata  (io_wdata),
        .cmd_q     (dma_cmd_q),
        .req_q     (dma_req_q),
        .mode_hi_q (dma_mode_q)
    );

    // Qualify reads that step a readback list
    always_comb begin
        rd_pic = alt_mode_en && io_rd && (io_addr == PIC_M_ADDR);
        rd_dma = alt_mode_en && io_rd && (io_addr == DMA_CMD);
    end

    seq_index #(.DEPTH(PIC_LEN)) i_pic_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (alt_mode_en),
        .step  (rd_pic),
        .idx   (pic_idx)
    );

    seq_index #(.DEPTH(DMA_LEN)) i_dma_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (alt_mode_en),
        .step  (rd_dma),
        .idx   (dma_idx)
    );

    // Interrupt readback list with reserved bits replaced
    always_comb begin
        for (int p = 0; p < N_PIC; p++) begin
            pic_view[p*PIC_WORDS + 0] = view_icw2(pic_regs[p].icw2);
            pic_view[p*PIC_WORDS + 1] = pic_regs[p].icw3;
            pic_view[p*PIC_WORDS + 2] = view_icw4(pic_regs[p].icw4);
            pic_view[p*PIC_WORDS + 3] = pic_regs[p].ocw1;
            pic_view[p*PIC_WORDS + 4] = view_ocw2(pic_regs[p].ocw2);
            pic_view[p*PIC_WORDS + 5] = view_ocw3(pic_regs[p].ocw3);
        end
    end

    // DMA readback list with channel codes rebuilt
    always_comb begin
        dma_view[0] = view_dcmd(dma_cmd_q);
        dma_view[1] = dma_req_q;
        for (int c = 0; c < N_DMA_CH; c++) begin
            dma_view[2 + c] = {dma_mode_q[c], CH_W'(c)};
        end
    end

    // Read data multiplexer
    always_comb begin
        if (rd_pic)      io_rdata = pic_view[pic_idx];
        else if (rd_dma) io_rdata = dma_view[dma_idx];
        else             io_rdata = '0;
    end

    // R7: ICW2 low bits and ICW4 reserved bits read as zero
    p_icw_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pic && (pic_idx == 0 || pic_idx == PIDX_W'(PIC_WORDS))) |-> io_rdata[2:0] == 3'b000);
    p_icw4_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pic && (pic_idx == 2 || pic_idx == PIDX_W'(PIC_WORDS + 2))) |-> (io_rdata & 8'hED) == 8'h00);

    // R8: OCW3 fixed and mirrored bits
    p_ocw3_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pic && (pic_idx == 5 || pic_idx == PIDX_W'(PIC_WORDS + 5)))
        |-> (io_rdata[7] == 1'b0 && io_rdata[4:3] == 2'b01 && io_rdata[5] == io_rdata[6]));

    // R9: DMA command reserved bits read zero
    p_dcmd_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dma && dma_idx == 0) |-> (io_rdata & 8'h2B) == 8'h00);

    // R6: mode words carry their channel code
    p_mode_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dma && dma_idx >= 2) |-> io_rdata[CH_W-1:0] == CH_W'(dma_idx - DIDX_W'(2)));

    // R11: nothing is returned outside the alternate mode
    p_quiet_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_mode_en |-> io_rdata == 8'h00);

endmodule

// File: tb/test_wo_shadow_readback.sv
// Directed bench: one task per scenario, each checking its own results.
module test_wo_shadow_readback;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_mode_en = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wo_shadow_readback i_wo_shadow_readback (
        .clk         (clk),
        .rst_n       (rst_n),
        .alt_mode_en (alt_mode_en),
        .io_addr     (io_addr),
        .io_wdata    (io_wdata),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_rdata    (io_rdata)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // One read: drive on a falling edge, sample before the rising edge
    task automatic io_read_chk(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, io_rdata, exp);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic set_alt(input logic v);
        @(negedge clk);
        alt_mode_en = v;
    endtask

    // Reset state: nothing returned, shadows cleared
    task automatic t_reset();
        io_read_chk(16'h0020, 8'h00, "R11 reset off");
        set_alt(1'b1);
        io_read_chk(16'h0020, 8'h00, "R5 reset icw2");
        io_read_chk(16'h0020, 8'h00, "R5 reset icw3");
        io_read_chk(16'h00D0, 8'h00, "R6 reset cmd");
        set_alt(1'b0);
    endtask

    // Full programming of both controllers and the DMA block
    task automatic t_program_all();
        io_write(16'h0020, 8'h11);  // R1 ICW1: cascade, ICW4 needed
        io_write(16'h0021, 8'h0F);
        io_write(16'h0021, 8'h04);
        io_write(16'h0021, 8'hFF);
        io_write(16'h00A0, 8'h11);
        io_write(16'h00A1, 8'h77);
        io_write(16'h00A1, 8'h02);
        io_write(16'h00A1, 8'h01);
        io_write(16'h0021, 8'hA5);  // R3 OCW1
        io_write(16'h00A1, 8'h5A);
        io_write(16'h0020, 8'hE5);  // R3 OCW2
        io_write(16'h0020, 8'hCB);  // R3 OCW3
        io_write(16'h00A0, 8'h21);
        io_write(16'h00A0, 8'hAA);
        io_write(16'h00D0, 8'hFF);  // R4
        io_write(16'h00D2, 8'h06);
        io_write(16'h00D6, 8'hFC);
        io_write(16'h00D6, 8'h45);
        io_write(16'h00D6, 8'h8A);
        io_write(16'h00D6, 8'h33);
        io_write(16'h0044, 8'hFF);  // unrelated port
        io_read_chk(16'h0020, 8'h00, "R11 off after writes");
    endtask

    // Full ordered readback with interleaving and wrap
    task automatic t_readback_order();
        logic [7:0] pic_exp [12] = '{8'h08, 8'h04, 8'h12, 8'hA5, 8'hE5, 8'h6B,
                                     8'h70, 8'h02, 8'h00, 8'h5A, 8'h21, 8'h0A};
        logic [7:0] dma_exp [6]  = '{8'hD4, 8'h06, 8'hFC, 8'h45, 8'h8A, 8'h33};
        set_alt(1'b1);
        for (int i = 0; i < 3; i++) io_read_chk(16'h00D0, dma_exp[i], "R6 R9 dma order");
        for (int i = 0; i < 12; i++) io_read_chk(16'h0020, pic_exp[i], "R5 R7 R8 pic order");
        for (int i = 3; i < 6; i++) io_read_chk(16'h00D0, dma_exp[i], "R6 R10 dma after pic");
        io_read_chk(16'h0020, pic_exp[0], "R10 pic wrap");
        io_read_chk(16'h00D0, dma_exp[0], "R10 dma wrap");
        io_read_chk(16'h0021, 8'h00, "R11 other port");
        io_read_chk(16'h0020, pic_exp[1], "R10 other port no step");
    endtask

    // Leaving and re-entering the mode restarts both lists
    task automatic t_reentry();
        io_read_chk(16'h0020, 8'h12, "R10 before exit");
        set_alt(1'b0);
        io_read_chk(16'h0020, 8'h00, "R11 off read");
        set_alt(1'b1);
        io_read_chk(16'h0020, 8'h08, "R10 re-entry pic");
        io_read_chk(16'h00D0, 8'hD4, "R10 re-entry dma");
        set_alt(1'b0);
    endtask

    // Shortened initialization sequences and a single mode rewrite
    task automatic t_skip_sequences();
        io_write(16'h0020, 8'h12);  // R2 single mode, no ICW4
        io_write(16'h0021, 8'h30);
        io_write(16'h0021, 8'h99);  // becomes OCW1
        io_write(16'h00A0, 8'h10);  // R2 cascade, no ICW4
        io_write(16'h00A1, 8'h48);
        io_write(16'h00A1, 8'h07);
        io_write(16'h00A1, 8'h3C);  // becomes OCW1
        io_write(16'h00D6, 8'hF2);  // R4 channel 6 only
        set_alt(1'b1);
        io_read_chk(16'h0020, 8'h30, "R2 master icw2");
        io_read_chk(16'h0020, 8'h04, "R2 master icw3 kept");
        io_read_chk(16'h0020, 8'h12, "R2 master icw4 kept");
        io_read_chk(16'h0020, 8'h99, "R2 master ocw1");
        io_read_chk(16'h0020, 8'hE5, "R3 master ocw2 kept");
        io_read_chk(16'h0020, 8'h6B, "R8 master ocw3");
        io_read_chk(16'h0020, 8'h48, "R2 slave icw2");
        io_read_chk(16'h0020, 8'h07, "R2 slave icw3");
        io_read_chk(16'h0020, 8'h00, "R2 slave icw4 kept");
        io_read_chk(16'h0020, 8'h3C, "R2 slave ocw1");
        for (int i = 0; i < 2; i++) io_read_chk(16'h00D0, (i == 0) ? 8'hD4 : 8'h06, "R6 dma head");
        io_read_chk(16'h00D0, 8'hFC, "R4 ch4 kept");
        io_read_chk(16'h00D0, 8'h45, "R4 ch5 kept");
        io_read_chk(16'h00D0, 8'hF2, "R4 ch6 updated");
        io_read_chk(16'h00D0, 8'h33, "R4 ch7 kept");
        set_alt(1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program_all();
        t_readback_order();
        t_reentry();
        t_skip_sequences();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule